// File: doc/BRIEF.md
# Voxel Bit-Plane Transposer

This block sits between a voxel stream and a multi-channel LED driver that runs in a reduced-depth grayscale mode. Such a driver takes its data one bit position at a time across all of its channels. The block gathers a group of sixteen RGB voxels, each holding three 9-bit colour values. It then re-issues the group as nine 48-bit plane words. Each word carries the same bit position of every colour channel of every LED in the group. The top bit position comes first.

Both sides use valid/ready handshakes. Two group buffers alternate roles: one fills from the input stream while the other is read out plane by plane. This lets the producer move on to the next group without waiting for the current one to drain. Serial shifting to the driver, clock domain crossing and display timing are handled elsewhere.

Top module: `voxel_plane_transposer`

## Requirements
- R1: After a synchronous active-low reset, out_valid is 0 and in_ready is 1.
- R2: A voxel is taken on every rising clock edge where in_valid and in_ready are both 1. One group is sixteen voxels, and the first voxel taken becomes LED 0.
- R3: out_valid stays 0 until all sixteen voxels of a group have been taken. It rises in the cycle after the sixteenth voxel is taken, provided no earlier group is still being read out.
- R4: Within a plane word, bit (LED × 3 + colour) carries the selected bit of that LED's colour channel, where red = 0, green = 1 and blue = 2. LED 0 occupies the least significant bits.
- R5: Each group produces exactly nine plane words. They come in the order bit 8, bit 7, and so on down to bit 0 of every channel.
- R6: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_plane does not change on the next cycle.
- R7: in_ready is 0 only when two complete groups are stored and not yet fully read out. While in_ready is 0, voxels offered on the input are not captured.
- R8: Groups are read out in the order in which they were completed. A group's buffer is freed when its bit-0 word is taken.
- R9: A reset in the middle of a group discards the partial group and both buffers. The plane counter returns to bit 8, and the next sixteen voxels form a fresh group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input voxel is offered |
| in_ready | output | 1 | Block can take a voxel |
| in_red | input | 9 | Red value of the offered voxel |
| in_green | input | 9 | Green value of the offered voxel |
| in_blue | input | 9 | Blue value of the offered voxel |
| out_valid | output | 1 | A plane word is presented |
| out_ready | input | 1 | Consumer takes the plane word |
| out_plane | output | 48 | Plane word, one bit per LED channel |

## Verification
The bench builds the block with its default parameters: sixteen LEDs and nine-bit channels. This gives the real 48-bit word layout and the full nine-plane sequence. Random throttling on both handshakes drives the ping-pong buffers into every occupancy: empty, one group held, and both held with input stalled. It also places the group boundary against every plane index of the group being drained. A reference model of occupancy predicts in_ready and out_valid on every cycle, and a reference transpose predicts each plane word.

// File: rtl/vxt_pkg.sv
// Package: shared constants for the voxel bit-plane transposer.
// Assumes: three colour channels per voxel, packed red, green, blue from bit 0 up.
package vxt_pkg;
    localparam int unsigned VXT_LEDS   = 16;
    localparam int unsigned VXT_DEPTH  = 9;
    localparam int unsigned VXT_COLORS = 3;
    localparam int unsigned VXT_BANKS  = 2;
endpackage

// File: rtl/vxt_wr_ctrl.sv
// Module: vxt_wr_ctrl
// Tracks which group buffer is filling and which LED slot takes the next voxel.
// Assumes: in_fire is asserted only when the selected buffer is free.
module vxt_wr_ctrl #(
    parameter int unsigned LEDS  = vxt_pkg::VXT_LEDS,
    localparam int unsigned IDX_W = $clog2(LEDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_fire,
    output logic             wr_sel,
    output logic [IDX_W-1:0] wr_idx,
    output logic             wr_last
);
    // Flags the slot that completes a group.
    always_comb wr_last = (wr_idx == IDX_W'(LEDS - 1));

    // Advances the slot on each accepted voxel and swaps buffers at group end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx <= '0;
            wr_sel <= 1'b0;
        end else if (in_fire) begin
            if (wr_last) begin
                wr_idx <= '0;
                wr_sel <= ~wr_sel;
            end else begin
                wr_idx <= wr_idx + 1'b1;
            end
        end
    end

    // A slot only moves when a voxel is taken.
    p_slot_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_fire |=> $stable(wr_idx) && $stable(wr_sel));
endmodule

// File: rtl/vxt_rd_ctrl.sv
// Module: vxt_rd_ctrl
// Tracks which group buffer is draining and which bit plane is presented next.
// Assumes: out_fire is asserted only while the selected buffer holds a full group.
module vxt_rd_ctrl #(
    parameter int unsigned DEPTH = vxt_pkg::VXT_DEPTH,
    localparam int unsigned PL_W  = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            out_fire,
    output logic            rd_sel,
    output logic [PL_W-1:0] plane_idx,
    output logic            rd_last
);
    // Flags the least significant plane, which ends a group.
    always_comb rd_last = (plane_idx == '0);

    // Counts planes down from the top bit and swaps buffers after plane zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plane_idx <= PL_W'(DEPTH - 1);
            rd_sel    <= 1'b0;
        end else if (out_fire) begin
            if (rd_last) begin
                plane_idx <= PL_W'(DEPTH - 1);
                rd_sel    <= ~rd_sel;
            end else begin
                plane_idx <= plane_idx - 1'b1;
            end
        end
    end

    // The plane counter never leaves the channel's bit range.
    p_plane_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        plane_idx <= PL_W'(DEPTH - 1));

    // The counter moves only when a word is taken.
    p_plane_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_fire |=> $stable(plane_idx) && $stable(rd_sel));
endmodule

// File: rtl/vxt_bank.sv
// Module: vxt_bank
// Holds one group of voxels and presents one bit plane of it as a transposed word.
// Assumes: voxel word packs colour c at bits [c*DEPTH +: DEPTH]; no reset on data.
module vxt_bank #(
    parameter int unsigned LEDS   = vxt_pkg::VXT_LEDS,
    parameter int unsigned DEPTH  = vxt_pkg::VXT_DEPTH,
    parameter int unsigned COLORS = vxt_pkg::VXT_COLORS,
    localparam int unsigned IDX_W  = $clog2(LEDS),
    localparam int unsigned PL_W   = $clog2(DEPTH),
    localparam int unsigned VOX_W  = COLORS * DEPTH,
    localparam int unsigned WORD_W = LEDS * COLORS
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VOX_W-1:0]  wr_voxel,
    input  logic [PL_W-1:0]   plane_idx,
    output logic [WORD_W-1:0] plane
);
    logic [VOX_W-1:0] mem [LEDS];

    // Stores an accepted voxel into its LED slot.
    always_ff @(posedge clk) begin
        if (we) mem[wr_idx] <= wr_voxel;
    end

    // Gathers the selected bit of every channel of every LED into one word.
    for (genvar led = 0; led < LEDS; led++) begin : g_led
        for (genvar c = 0; c < COLORS; c++) begin : g_col
            logic [DEPTH-1:0] chan;
            always_comb chan = mem[led][c*DEPTH +: DEPTH];
            always_comb plane[led*COLORS + c] = chan[plane_idx];
        end
    end
endmodule

// File: rtl/voxel_plane_transposer.sv
// Module: voxel_plane_transposer
// Collects groups of LEDS voxels into two alternating buffers and emits each
// group as DEPTH bit-plane words, top bit first.
// Assumes: synchronous active-low reset; consumer follows valid/ready rules.
module voxel_plane_transposer #(
    parameter int unsigned LEDS  = vxt_pkg::VXT_LEDS,
    parameter int unsigned DEPTH = vxt_pkg::VXT_DEPTH,
    localparam int unsigned COLORS = vxt_pkg::VXT_COLORS,
    localparam int unsigned BANKS  = vxt_pkg::VXT_BANKS,
    localparam int unsigned IDX_W  = $clog2(LEDS),
    localparam int unsigned PL_W   = $clog2(DEPTH),
    localparam int unsigned VOX_W  = COLORS * DEPTH,
    localparam int unsigned WORD_W = LEDS * COLORS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DEPTH-1:0]  in_red,
    input  logic [DEPTH-1:0]  in_green,
    input  logic [DEPTH-1:0]  in_blue,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_plane
);
    logic              wr_sel, rd_sel, wr_last, rd_last;
    logic [IDX_W-1:0]  wr_idx;
    logic [PL_W-1:0]   plane_idx;
    logic [BANKS-1:0]  buf_full;
    logic              in_fire, out_fire;
    logic [VOX_W-1:0]  voxel;
    logic [WORD_W-1:0] bank_plane [BANKS];

    // Handshake decode and voxel packing, red in the low channel.
    always_comb begin
        in_ready  = !buf_full[wr_sel];
        out_valid = buf_full[rd_sel];
        in_fire   = in_valid && in_ready;
        out_fire  = out_valid && out_ready;
        voxel     = {in_blue, in_green, in_red};
        out_plane = bank_plane[rd_sel];
    end

    vxt_wr_ctrl #(.LEDS(LEDS)) u_wr (
        .clk(clk), .rst_n(rst_n), .in_fire(in_fire),
        .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_last(wr_last)
    );

    vxt_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
        .clk(clk), .rst_n(rst_n), .out_fire(out_fire),
        .rd_sel(rd_sel), .plane_idx(plane_idx), .rd_last(rd_last)
    );

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        vxt_bank #(.LEDS(LEDS), .DEPTH(DEPTH), .COLORS(COLORS)) u_bank (
            .clk(clk),
            .we(in_fire && (wr_sel == 1'(g))),
            .wr_idx(wr_idx),
            .wr_voxel(voxel),
            .plane_idx(plane_idx),
            .plane(bank_plane[g])
        );
    end

    // Marks a buffer full when its last voxel lands and empty after plane zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_full <= '0;
        end else begin
            if (in_fire && wr_last) buf_full[wr_sel] <= 1'b1;
            if (out_fire && rd_last) buf_full[rd_sel] <= 1'b0;
        end
    end

    // Fresh out of reset, nothing is offered and input is open.
    p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid && in_ready);

    // A completed group's buffer is flagged full on the next cycle.
    p_group_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire && wr_last |=> buf_full[$past(wr_sel)]);

    // A stalled word stays valid and unchanged.
    p_hold_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_plane));

    // Input stalls only with both buffers occupied.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (buf_full == '1));

    // Taking plane zero frees the drained buffer.
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_fire && rd_last |=> !buf_full[$past(rd_sel)]);
endmodule

// File: tb/test_voxel_plane_transposer.sv
module test_voxel_plane_transposer;
    localparam int LEDS  = 16;
    localparam int DEPTH = 9;
    localparam int PW    = LEDS * 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic in_valid = 1'b0, out_ready = 1'b0;
    logic in_ready, out_valid;
    logic [DEPTH-1:0] in_red = '0, in_green = '0, in_blue = '0;
    logic [PW-1:0] out_plane;

    voxel_plane_transposer i_voxel_plane_transposer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_red(in_red), .in_green(in_green), .in_blue(in_blue),
        .out_valid(out_valid), .out_ready(out_ready), .out_plane(out_plane)
    );

    int n_vec = 0, n_bad = 0;
    bit finished = 0;
    logic [DEPTH-1:0] pr [LEDS], pg [LEDS], pb [LEDS];
    int pend_n = 0;
    logic [PW-1:0] exp_q [$];
    bit prev_hold = 0;
    logic [PW-1:0] prev_plane = '0;

    function automatic logic [PW-1:0] make_plane(int b);
        logic [PW-1:0] w;
        for (int led = 0; led < LEDS; led++) begin
            w[led*3 + 0] = pr[led][b];
            w[led*3 + 1] = pg[led][b];
            w[led*3 + 2] = pb[led][b];
        end
        return w;
    endfunction

    task automatic check(bit ok, string req, logic [PW-1:0] act, logic [PW-1:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check, then update the model.
    task automatic step(bit v, logic [DEPTH-1:0] r, logic [DEPTH-1:0] g,
                        logic [DEPTH-1:0] b, bit ordy);
        int groups;
        @(negedge clk);
        in_valid = v; in_red = r; in_green = g; in_blue = b; out_ready = ordy;
        #1;
        groups = (exp_q.size() + DEPTH - 1) / DEPTH;
        check(in_ready == (groups < 2), "R2/R7 in_ready", PW'(in_ready), PW'(groups < 2));
        check(out_valid == (exp_q.size() > 0), "R3 out_valid", PW'(out_valid), PW'(exp_q.size() > 0));
        if (prev_hold)
            check(out_valid && out_plane == prev_plane, "R6 stalled word", out_plane, prev_plane);
        if (out_valid && exp_q.size() > 0)
            check(out_plane == exp_q[0], "R4/R5/R8 plane word", out_plane, exp_q[0]);
        prev_hold  = out_valid && !ordy;
        prev_plane = out_plane;
        if (out_valid && ordy && exp_q.size() > 0) void'(exp_q.pop_front());
        if (v && in_ready) begin
            pr[pend_n] = r; pg[pend_n] = g; pb[pend_n] = b;
            pend_n++;
            if (pend_n == LEDS) begin
                for (int bit_i = DEPTH - 1; bit_i >= 0; bit_i--) exp_q.push_back(make_plane(bit_i));
                pend_n = 0;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        exp_q.delete(); pend_n = 0; prev_hold = 0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_bad++;
            $display("FAIL R2 watchdog expired actual 0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20511));
        do_reset();
        #1;
        // R1: reset state at the ports.
        check(!out_valid && in_ready, "R1 reset state", PW'({out_valid, in_ready}), PW'(2'b01));

        // R4: single set bit, blue of LED 3, bit 8, lands at word bit 11.
        for (int i = 0; i < LEDS; i++)
            step(1'b1, '0, '0, (i == 3) ? 9'h100 : 9'h000, 1'b0);
        step(1'b0, '0, '0, '0, 1'b0);
        check(out_plane == PW'(48'h800), "R4 bit placement", out_plane, PW'(48'h800));
        for (int i = 0; i < DEPTH + 2; i++) step(1'b0, '0, '0, '0, 1'b1);

        // R5: red of LED 0 at bit 0 only shows in the ninth word.
        for (int i = 0; i < LEDS; i++) step(1'b1, (i == 0) ? 9'h001 : 9'h000, '0, '0, 1'b0);
        for (int i = 0; i < DEPTH - 1; i++) begin
            step(1'b0, '0, '0, '0, 1'b1);
            check(out_plane == '0, "R5 upper planes empty", out_plane, '0);
        end
        step(1'b0, '0, '0, '0, 1'b0);
        check(out_plane == PW'(1), "R5 last plane", out_plane, PW'(1));
        step(1'b0, '0, '0, '0, 1'b1);

        // R7: fill both buffers, offer junk while stalled, then drain.
        for (int i = 0; i < 2 * LEDS; i++)
            step(1'b1, 9'($urandom), 9'($urandom), 9'($urandom), 1'b0);
        for (int i = 0; i < 6; i++) begin
            step(1'b1, 9'h1FF, 9'h1FF, 9'h1FF, 1'b0);
            check(!in_ready, "R7 stalled input", PW'(in_ready), '0);
        end
        for (int i = 0; i < 2 * DEPTH + 3; i++) step(1'b0, '0, '0, '0, 1'b1);

        // R9: reset midway through a group, then a fresh group.
        for (int i = 0; i < 7; i++) step(1'b1, 9'h1FF, 9'h0AA, 9'h155, 1'b1);
        do_reset();
        #1;
        check(!out_valid && in_ready, "R9 reset mid group", PW'({out_valid, in_ready}), PW'(2'b01));
        for (int i = 0; i < LEDS; i++)
            step(1'b1, 9'(i * 37), 9'(i * 11 + 5), 9'(500 - i), 1'b0);
        for (int i = 0; i < DEPTH + 2; i++) step(1'b0, '0, '0, '0, 1'b1);

        // Random throttling on both sides.
        for (int i = 0; i < 4000; i++) begin
            bit v, rdy;
            v   = ($urandom % 4) != 0;
            rdy = ($urandom % 3) == 0 ? 1'b0 : ((i / 500) % 2 == 0);
            step(v, 9'($urandom), 9'($urandom), 9'($urandom), rdy | ((i / 250) % 2 == 1));
        end
        for (int i = 0; i < 3 * DEPTH; i++) step(1'b0, '0, '0, '0, 1'b1);

        finished = 1;
        summary();
        $finish;
    end
endmodule